// File: doc/BRIEF.md
# Power Domain Disconnect Unit

This unit sits on a transaction link that crosses a power domain boundary. The link has a request path and a response path, each with a valid/ready handshake. The unit keeps a running count of transactions that have gone across and not yet been answered. A system power manager drives a disconnect request into the unit. The unit then closes the request path, lets the outstanding responses return, and raises an acknowledge once nothing is pending. From that point the far domain may be switched off safely.

The unit is built around a three-state controller:

- `ST_ONLINE` passes requests through.
- `ST_DRAINING` blocks new requests and waits for the pending count to reach zero.
- `ST_OFFLINE` holds the acknowledge high.

The transitions are as follows:

- ONLINE → DRAINING when the disconnect request is seen.
- DRAINING → OFFLINE when the registered count is zero while the request is still held.
- DRAINING → ONLINE or OFFLINE → ONLINE when the request is withdrawn.

The request path is gated by the registered state, never directly by the request input. A request that completes its handshake in the same cycle the disconnect request first appears is therefore still passed and counted. The response path is never gated.

The pending counter saturates at both ends and records sticky error flags. An underflow is a response with nothing pending. An overflow is a request arriving when the count is already at its maximum.

Top module: `domain_disconnect`

## Requirements
- R1: In ST_ONLINE the request path is transparent: `dn_req_valid` equals `up_req_valid`, `up_req_ready` equals `dn_req_ready`, and `dn_req_data` equals `up_req_data`.
- R2: `pend_cnt` rises by one after each request handshake (`up_req_valid & up_req_ready`) and falls by one after each response handshake (`dn_rsp_valid & up_rsp_ready`). When both occur in one cycle it is unchanged.
- R3: In the cycle after `iso_req` is sampled high in ST_ONLINE, the unit is in ST_DRAINING. From then on, both `up_req_ready` and `dn_req_valid` are held low.
- R4: A request handshaking in the first cycle that `iso_req` is high is forwarded and counted.
- R5: `iso_ack` rises one cycle after a clock edge at which the unit is in ST_DRAINING with `pend_cnt` zero. While `iso_ack` is high, `pend_cnt` is zero. From an idle ONLINE state, `iso_ack` is high two edges after `iso_req` rises.
- R6: While `iso_req` stays high in ST_OFFLINE, `iso_ack` stays high and the request path stays closed.
- R7: When `iso_req` is sampled low in ST_DRAINING or ST_OFFLINE, the next state is ST_ONLINE, `iso_ack` is low, and the request path reopens.
- R8: A response handshake with `pend_cnt` zero and no request in the same cycle leaves `pend_cnt` at zero and sets the sticky `err_underflow`.
- R9: A request handshake with `pend_cnt` at MAX_PENDING (default 15) and no response in the same cycle leaves `pend_cnt` at MAX_PENDING and sets the sticky `err_overflow`.
- R10: After reset (`rst_n` low), the unit is in ST_ONLINE with `pend_cnt` zero, `iso_ack` low and both error flags low.
- R11: The response path is transparent in every state: `up_rsp_valid` equals `dn_rsp_valid`, `dn_rsp_ready` equals `up_rsp_ready`, and `up_rsp_data` equals `dn_rsp_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| up_req_valid | input | 1 | Request valid from the initiator side |
| up_req_ready | output | 1 | Request ready to the initiator side |
| up_req_data | input | REQ_W | Request payload from the initiator side |
| dn_req_valid | output | 1 | Request valid into the switched domain |
| dn_req_ready | input | 1 | Request ready from the switched domain |
| dn_req_data | output | REQ_W | Request payload into the switched domain |
| dn_rsp_valid | input | 1 | Response valid from the switched domain |
| dn_rsp_ready | output | 1 | Response ready to the switched domain |
| dn_rsp_data | input | RSP_W | Response payload from the switched domain |
| up_rsp_valid | output | 1 | Response valid to the initiator side |
| up_rsp_ready | input | 1 | Response ready from the initiator side |
| up_rsp_data | output | RSP_W | Response payload to the initiator side |
| iso_req | input | 1 | Disconnect request from the power manager |
| iso_ack | output | 1 | Domain safe to power off |
| pend_cnt | output | CNT_W | Outstanding transaction count |
| err_overflow | output | 1 | Sticky: request arrived at full count |
| err_underflow | output | 1 | Sticky: response arrived with nothing pending |

## Verification
The bench targets the cycle in which the disconnect request first rises while a request is handshaking. A design that gated the path directly from the request input would drop or miscount that transaction.

It also checks the following cases:

- **Drain edge.** The acknowledge must appear only once the last response has been counted. A design that compared the next count instead of the registered one, or ignored in-flight responses, would acknowledge one cycle early or with work still pending.
- **Simultaneous request and response.** A miscounting design would drift by one.
- **Counter ends.** Underflow and overflow must saturate and flag. A wrapping counter would report 15 or 0.
- **Withdrawal.** Withdrawing the request must drop the acknowledge and reopen the path on the next edge.

// File: rtl/dd_pkg.sv
package dd_pkg;

    typedef enum logic [1:0] {
        ST_ONLINE   = 2'd0,
        ST_DRAINING = 2'd1,
        ST_OFFLINE  = 2'd2
    } dd_state_e;

endpackage

// File: rtl/dd_pending_counter.sv
module dd_pending_counter #(
    parameter int MAX_PENDING = 15,
    localparam int CNT_W      = $clog2(MAX_PENDING + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             dec,
    output logic [CNT_W-1:0] cnt,
    output logic             ovf_err,
    output logic             unf_err
);

    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_PENDING);

    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             ovf_q, unf_q;
    logic             ovf_set, unf_set;

    always_comb begin
        cnt_d   = cnt_q;
        ovf_set = 1'b0;
        unf_set = 1'b0;
        unique case ({inc, dec})
            2'b10: begin
                if (cnt_q == CNT_MAX) ovf_set = 1'b1;
                else                  cnt_d   = cnt_q + CNT_W'(1);
            end
            2'b01: begin
                if (cnt_q == '0) unf_set = 1'b1;
                else             cnt_d   = cnt_q - CNT_W'(1);
            end
            default: cnt_d = cnt_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            ovf_q <= 1'b0;
            unf_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            ovf_q <= ovf_q | ovf_set;
            unf_q <= unf_q | unf_set;
        end
    end

    assign cnt     = cnt_q;
    assign ovf_err = ovf_q;
    assign unf_err = unf_q;

    // R2: the count never moves by more than one per cycle
    assert_single_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == $past(cnt_q)) ||
        ({1'b0, cnt_q} == {1'b0, $past(cnt_q)} + (CNT_W+1)'(1)) ||
        ({1'b0, cnt_q} + (CNT_W+1)'(1) == {1'b0, $past(cnt_q)}));

    // R9: saturates at the configured maximum
    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_MAX);

    // R8: an unmatched response leaves the count at zero
    assert_floor_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !inc && cnt_q == '0) |=> (cnt_q == '0 && unf_q));

endmodule

// File: rtl/dd_fsm.sv
module dd_fsm
    import dd_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      iso_req,
    input  logic      cnt_zero,
    output dd_state_e state,
    output logic      gate_open,
    output logic      ack
);

    dd_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ONLINE: begin
                if (iso_req) state_d = ST_DRAINING;
            end
            ST_DRAINING: begin
                if (!iso_req)     state_d = ST_ONLINE;
                else if (cnt_zero) state_d = ST_OFFLINE;
            end
            ST_OFFLINE: begin
                if (!iso_req) state_d = ST_ONLINE;
            end
            default: state_d = ST_ONLINE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_ONLINE;
        else        state_q <= state_d;
    end

    always_comb begin
        gate_open = 1'b0;
        ack       = 1'b0;
        unique case (state_q)
            ST_ONLINE:   gate_open = 1'b1;
            ST_DRAINING: gate_open = 1'b0;
            ST_OFFLINE:  ack       = 1'b1;
            default: begin
                gate_open = 1'b0;
                ack       = 1'b0;
            end
        endcase
    end

    assign state = state_q;

    // R6: acknowledge holds while the request stays high
    assert_ack_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && iso_req) |=> ack);

    // R7: withdrawing the request drops the acknowledge and reopens the gate
    assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !iso_req |=> (!ack && gate_open));

    // R3: a request seen while online leads to a closed gate next cycle
    assert_close_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (iso_req && state_q == ST_ONLINE) |=> !gate_open);

endmodule

// File: rtl/domain_disconnect.sv
module domain_disconnect
    import dd_pkg::*;
#(
    parameter int REQ_W       = 32,
    parameter int RSP_W       = 32,
    parameter int MAX_PENDING = 15,
    localparam int CNT_W      = $clog2(MAX_PENDING + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             up_req_valid,
    output logic             up_req_ready,
    input  logic [REQ_W-1:0] up_req_data,
    output logic             dn_req_valid,
    input  logic             dn_req_ready,
    output logic [REQ_W-1:0] dn_req_data,
    input  logic             dn_rsp_valid,
    output logic             dn_rsp_ready,
    input  logic [RSP_W-1:0] dn_rsp_data,
    output logic             up_rsp_valid,
    input  logic             up_rsp_ready,
    output logic [RSP_W-1:0] up_rsp_data,
    input  logic             iso_req,
    output logic             iso_ack,
    output logic [CNT_W-1:0] pend_cnt,
    output logic             err_overflow,
    output logic             err_underflow
);

    dd_state_e        state;
    logic             gate_open;
    logic             req_fire, rsp_fire;
    logic [CNT_W-1:0] cnt;

    // request path gated by registered state only
    assign dn_req_valid = up_req_valid & gate_open;
    assign up_req_ready = dn_req_ready & gate_open;
    assign dn_req_data  = up_req_data;
    assign req_fire     = up_req_valid & dn_req_ready & gate_open;

    // response path always open so the drain can finish
    assign up_rsp_valid = dn_rsp_valid;
    assign dn_rsp_ready = up_rsp_ready;
    assign up_rsp_data  = dn_rsp_data;
    assign rsp_fire     = dn_rsp_valid & up_rsp_ready;

    dd_pending_counter #(
        .MAX_PENDING (MAX_PENDING)
    ) u_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc     (req_fire),
        .dec     (rsp_fire),
        .cnt     (cnt),
        .ovf_err (err_overflow),
        .unf_err (err_underflow)
    );

    dd_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .iso_req   (iso_req),
        .cnt_zero  (cnt == '0),
        .state     (state),
        .gate_open (gate_open),
        .ack       (iso_ack)
    );

    assign pend_cnt = cnt;

    // R5: acknowledge only with nothing outstanding
    assert_ack_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
        iso_ack |-> (cnt == '0));

    // R6: no request enters while the domain is reported off
    assert_offline_closed_R6: assert property (@(posedge clk) disable iff (!rst_n)
        iso_ack |-> !dn_req_valid);

    // R3: nothing is counted in while draining
    assert_drain_no_inc_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DRAINING) |=> (cnt <= $past(cnt)));

endmodule

// File: tb/test_domain_disconnect.sv
module test_domain_disconnect;

    localparam int REQ_W = 32;
    localparam int RSP_W = 32;
    localparam int MAXP  = 15;
    localparam int CW    = $clog2(MAXP + 1);

    logic             clk = 1'b0;
    logic             rst_n;
    logic             up_req_valid, up_req_ready;
    logic [REQ_W-1:0] up_req_data;
    logic             dn_req_valid, dn_req_ready;
    logic [REQ_W-1:0] dn_req_data;
    logic             dn_rsp_valid, dn_rsp_ready;
    logic [RSP_W-1:0] dn_rsp_data;
    logic             up_rsp_valid, up_rsp_ready;
    logic [RSP_W-1:0] up_rsp_data;
    logic             iso_req, iso_ack;
    logic [CW-1:0]    pend_cnt;
    logic             err_overflow, err_underflow;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    domain_disconnect #(.REQ_W(REQ_W), .RSP_W(RSP_W), .MAX_PENDING(MAXP)) i_domain_disconnect (
        .clk(clk), .rst_n(rst_n),
        .up_req_valid(up_req_valid), .up_req_ready(up_req_ready), .up_req_data(up_req_data),
        .dn_req_valid(dn_req_valid), .dn_req_ready(dn_req_ready), .dn_req_data(dn_req_data),
        .dn_rsp_valid(dn_rsp_valid), .dn_rsp_ready(dn_rsp_ready), .dn_rsp_data(dn_rsp_data),
        .up_rsp_valid(up_rsp_valid), .up_rsp_ready(up_rsp_ready), .up_rsp_data(up_rsp_data),
        .iso_req(iso_req), .iso_ack(iso_ack), .pend_cnt(pend_cnt),
        .err_overflow(err_overflow), .err_underflow(err_underflow)
    );

    typedef struct packed {
        logic       reqv;
        logic       rspv;
        logic       iso;
        logic       rdy;
        logic [3:0] cnt;
        logic       ack;
    } vec_t;

    // drive reqv/rspv/iso for one cycle; rdy is expected before the edge,
    // cnt/ack after it
    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 1'b0, 1'b0, 1'b1, 4'd1, 1'b0},  // R2 inc
        '{1'b1, 1'b0, 1'b0, 1'b1, 4'd2, 1'b0},  // R2 inc
        '{1'b1, 1'b1, 1'b0, 1'b1, 4'd2, 1'b0},  // R2 both
        '{1'b0, 1'b1, 1'b0, 1'b1, 4'd1, 1'b0},  // R2 dec
        '{1'b1, 1'b0, 1'b1, 1'b1, 4'd2, 1'b0},  // R4 same-cycle request
        '{1'b1, 1'b0, 1'b1, 1'b0, 4'd2, 1'b0},  // R3 blocked
        '{1'b1, 1'b1, 1'b1, 1'b0, 4'd1, 1'b0},  // R3 drain
        '{1'b0, 1'b1, 1'b1, 1'b0, 4'd0, 1'b0},  // R5 not yet
        '{1'b0, 1'b0, 1'b1, 1'b0, 4'd0, 1'b1},  // R5 ack
        '{1'b1, 1'b0, 1'b1, 1'b0, 4'd0, 1'b1},  // R6 hold
        '{1'b0, 1'b0, 1'b0, 1'b0, 4'd0, 1'b0},  // R7 release
        '{1'b1, 1'b0, 1'b0, 1'b1, 4'd1, 1'b0},  // R7 reopened
        '{1'b0, 1'b1, 1'b0, 1'b1, 4'd0, 1'b0},  // R2 dec
        '{1'b0, 1'b1, 1'b0, 1'b1, 4'd0, 1'b0}   // R8 underflow
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        up_req_valid = 1'b0; dn_req_ready = 1'b1; up_req_data = '0;
        dn_rsp_valid = 1'b0; up_rsp_ready = 1'b1; dn_rsp_data = '0;
        iso_req = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic drive(input logic rq, input logic rs, input logic iso);
        @(negedge clk);
        up_req_valid = rq;
        dn_rsp_valid = rs;
        iso_req      = iso;
    endtask

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                n_run++; n_fail++;
                $display("FAIL watchdog actual=%0d expected<=150000", cyc);
                $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
                $finish;
            end
        end
    end

    initial begin
        do_reset();
        #1;
        check("R10 cnt", 32'(pend_cnt), 0);
        check("R10 ack", 32'(iso_ack), 0);
        check("R10 ovf", 32'(err_overflow), 0);
        check("R10 unf", 32'(err_underflow), 0);

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i].reqv, VEC[i].rspv, VEC[i].iso);
            #1;
            check($sformatf("vec%0d rdy", i), 32'(up_req_ready), 32'(VEC[i].rdy));
            @(posedge clk);
            #1;
            check($sformatf("vec%0d cnt", i), 32'(pend_cnt), 32'(VEC[i].cnt));
            check($sformatf("vec%0d ack", i), 32'(iso_ack), 32'(VEC[i].ack));
        end
        check("R8 underflow flag", 32'(err_underflow), 1);
        check("R8 no overflow", 32'(err_overflow), 0);

        // R10 reset clears the sticky flag
        do_reset();
        #1;
        check("R10 unf cleared", 32'(err_underflow), 0);

        // R9 overflow at full count
        for (int i = 0; i < MAXP; i++) drive(1'b1, 1'b0, 1'b0);
        @(posedge clk); #1;
        check("R9 full count", 32'(pend_cnt), MAXP);
        check("R9 no flag yet", 32'(err_overflow), 0);
        drive(1'b1, 1'b0, 1'b0);
        @(posedge clk); #1;
        check("R9 saturated", 32'(pend_cnt), MAXP);
        check("R9 flag", 32'(err_overflow), 1);

        // R1 request pass-through, R5 idle timing
        do_reset();
        @(negedge clk);
        up_req_valid = 1'b1; up_req_data = 32'hA5C3_0F96; dn_req_ready = 1'b0;
        #1;
        check("R1 valid", 32'(dn_req_valid), 1);
        check("R1 data", dn_req_data, 32'hA5C3_0F96);
        check("R1 ready low", 32'(up_req_ready), 0);
        dn_req_ready = 1'b1;
        #1;
        check("R1 ready high", 32'(up_req_ready), 1);
        @(negedge clk);
        up_req_valid = 1'b0;
        @(negedge clk);
        dn_rsp_valid = 1'b1;
        @(negedge clk);
        dn_rsp_valid = 1'b0;
        #1;
        check("R2 back to zero", 32'(pend_cnt), 0);
        iso_req = 1'b1;
        @(posedge clk); #1;
        check("R5 not after one edge", 32'(iso_ack), 0);
        @(posedge clk); #1;
        check("R5 ack after two edges", 32'(iso_ack), 1);

        // R11 response passes while offline; R6 request path closed
        @(negedge clk);
        up_req_valid = 1'b1;
        dn_rsp_valid = 1'b1; dn_rsp_data = 32'h1357_9BDF; up_rsp_ready = 1'b0;
        #1;
        check("R6 closed", 32'(dn_req_valid), 0);
        check("R11 valid", 32'(up_rsp_valid), 1);
        check("R11 data", up_rsp_data, 32'h1357_9BDF);
        check("R11 ready", 32'(dn_rsp_ready), 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule